// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder, each on its own output. Each operation selects signed or unsigned arithmetic. A single restoring engine retires one quotient bit per clock. All four size and sign variants therefore take the same sixteen iterations.

A client drives the operands and pulses `start` while the block is idle. The block captures everything on that edge. It raises `busy` for the iterations and pulses `done` when the results are ready. The results and flags then hold until the next accepted start. A zero divisor and a quotient too large for 16 bits are reported on flag outputs. In both of those cases the quotient and remainder carry no defined value.

Top module: `int_divider`

## Requirements
- R1: A `start` pulse while `busy` is low captures `signed_op`, `wide_op`, `dividend_hi`, `dividend_lo` and `divisor` on that clock edge, and `busy` is high from the next cycle.
- R2: `done` is high for exactly one cycle. It rises 16 clock edges after the edge that accepted `start`, and `busy` is low in that same cycle.
- R3: A `start` pulse while `busy` is high is ignored, and the running operation finishes with its original operands.
- R4: Unsigned mode (`signed_op`=0) yields quotient = floor(dividend/divisor) and remainder = dividend − quotient·divisor, with both read as unsigned values.
- R5: With `wide_op`=1 the dividend is {`dividend_hi`,`dividend_lo`}. With `wide_op`=0 it is `dividend_lo` alone, sign-extended in signed mode and zero-extended in unsigned mode, and `dividend_hi` has no effect.
- R6: Signed mode (`signed_op`=1) uses two's complement. The quotient truncates toward zero, and the remainder takes the sign of the dividend, so that dividend = quotient·divisor + remainder.
- R7: When the divisor is zero, `div_zero` is 1 and `overflow` is 0 from the `done` cycle onward. Otherwise `div_zero` is 0.
- R8: When the divisor is nonzero, `overflow` is 1 exactly when the true quotient lies outside 0..65535 in unsigned mode, or outside −32768..32767 in signed mode.
- R9: Latency is the same for all four combinations of `signed_op` and `wide_op`.
- R10: After `done`, the quotient, remainder and both flags keep their values until the next accepted `start`, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| signed_op | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| wide_op | input | 1 | 1 = 32-bit dividend, 0 = 16-bit dividend |
| dividend_hi | input | 16 | Upper dividend word (used when wide) |
| dividend_lo | input | 16 | Lower dividend word |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient result |
| remainder | output | 16 | Remainder result |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient does not fit in 16 bits |

## Verification
Random operations mix both sizes and both signs. The wide high word is often kept small so that most results fit, while the rest of the operations overflow. This separates the value paths from the overflow detection. Directed cases cover the two signed extremes (−32768 fits, +32768 does not, and the most negative dividend over −1), the largest unsigned quotient that still fits, and remainder signs in all four sign quadrants. They also cover a zero divisor, a junk high word on 16-bit operations to show that it is ignored, and a start pulse in mid-operation. Every operation is timed, so latency differences between modes show up, and outputs are sampled again after the operand inputs are scrambled with no start pulse.

// File: rtl/int_divider.sv
module int_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_op,
  input  logic         wide_op,
  input  logic [W-1:0] dividend_hi,
  input  logic [W-1:0] dividend_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero,
  output logic         overflow
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

  logic [2*W-1:0] num_full, num_mag;
  logic [W-1:0]   dvs_mag;
  logic           num_neg, dvs_neg;

  assign num_full = wide_op   ? {dividend_hi, dividend_lo} :
                    signed_op ? {{W{dividend_lo[W-1]}}, dividend_lo} :
                                {{W{1'b0}}, dividend_lo};
  assign num_neg  = signed_op & num_full[2*W-1];
  assign dvs_neg  = signed_op & divisor[W-1];
  assign num_mag  = num_neg ? -num_full : num_full;
  assign dvs_mag  = dvs_neg ? -divisor : divisor;

  logic [W-1:0]  part_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, sgn_q, qneg_q, rneg_q, dz_q, ovfu_q;

  logic [W:0]   trial, diff;
  logic         fits;
  logic [W-1:0] part_nx;

  assign trial   = {part_q, quo_q[W-1]};
  assign diff    = trial - {1'b0, dvs_q};
  assign fits    = trial >= {1'b0, dvs_q};
  assign part_nx = fits ? diff[W-1:0] : trial[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sgn_q  <= 1'b0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
      ovfu_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        part_q <= part_nx;
        quo_q  <= {quo_q[W-2:0], fits};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        part_q <= num_mag[2*W-1:W];
        quo_q  <= num_mag[W-1:0];
        dvs_q  <= dvs_mag;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        sgn_q  <= signed_op;
        qneg_q <= num_neg ^ dvs_neg;
        rneg_q <= num_neg;
        dz_q   <= (divisor == '0);
        ovfu_q <= num_mag[2*W-1:W] >= dvs_mag;
      end
    end
  end

  logic sovf;
  assign sovf      = qneg_q ? (quo_q > MIN_MAG) : quo_q[W-1];
  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = qneg_q ? -quo_q : quo_q;
  assign remainder = rneg_q ? -part_q : part_q;
  assign div_zero  = dz_q;
  assign overflow  = !dz_q && (ovfu_q || (sgn_q && sovf));

  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  assert_ignore_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dvs_q));
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_q && !ovfu_q) |-> (part_q < dvs_q));
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < CW'(W)));
endmodule

// File: tb/int_divider_tb.sv
module int_divider_tb;
  localparam int PERIOD = 10;
  localparam int LAT = 16;

  logic clk = 0, rst_n = 0, start = 0, signed_op = 0, wide_op = 0;
  logic [15:0] dividend_hi = 0, dividend_lo = 0, divisor = 0;
  logic busy, done, div_zero, overflow;
  logic [15:0] quotient, remainder;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  int_divider u_dut (.clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
    .wide_op(wide_op), .dividend_hi(dividend_hi), .dividend_lo(dividend_lo),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_zero(div_zero), .overflow(overflow));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit s, input bit w, input logic [15:0] hi, lo, d,
                                output logic [15:0] eq, er, output bit edz, eov);
    longint n, dd, q, r;
    if (s) n = w ? longint'($signed({hi, lo})) : longint'($signed(lo));
    else   n = w ? longint'({hi, lo}) : longint'(lo);
    dd = s ? longint'($signed(d)) : longint'(d);
    edz = (d == 0);
    eov = 0; eq = 0; er = 0;
    if (edz) return;
    q = n / dd;
    r = n % dd;
    eov = s ? (q > 32767 || q < -32768) : (q > 65535);
    eq = q[15:0];
    er = r[15:0];
  endfunction

  task automatic run(input bit s, input bit w, input logic [15:0] hi, lo, d,
                     input bit poke_mid, input bit poke_after);
    logic [15:0] eq, er;
    bit edz, eov;
    int cyc = 0;
    model(s, w, hi, lo, d, eq, er, edz, eov);
    @(negedge clk);
    signed_op = s; wide_op = w; dividend_hi = hi; dividend_lo = lo; divisor = d; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy after start", busy, 1);
    while (done !== 1'b1 && cyc < 100) begin
      if (poke_mid && cyc == 5) begin
        signed_op = ~s; wide_op = ~w; dividend_hi = ~hi; dividend_lo = ~lo;
        divisor = d ^ 16'h0055; start = 1;
      end else start = 0;
      @(negedge clk);
      cyc++;
    end
    start = 0;
    chk(cyc == LAT, "R2/R9 latency", cyc, LAT);
    chk(busy === 1'b0, "R2 busy low at done", busy, 0);
    chk(div_zero === edz, "R7 div_zero", div_zero, edz);
    if (!edz) chk(overflow === eov, "R8 overflow", overflow, eov);
    else chk(overflow === 1'b0, "R7 overflow clear on zero divisor", overflow, 0);
    if (!edz && !eov) begin
      chk(quotient === eq, s ? "R6 quotient" : (w ? "R4 quotient" : "R5 quotient"), quotient, eq);
      chk(remainder === er, s ? "R6 remainder" : (w ? "R4 remainder" : "R5 remainder"), remainder, er);
      if (poke_mid) chk(quotient === eq && remainder === er, "R3 mid start ignored", quotient, eq);
    end
    @(negedge clk);
    chk(done === 1'b0, "R2 done single cycle", done, 0);
    if (poke_after && !edz && !eov) begin
      dividend_hi = $urandom; dividend_lo = $urandom; divisor = $urandom;
      signed_op = ~s; wide_op = ~w;
      repeat (3) @(negedge clk);
      chk(quotient === eq && remainder === er && overflow === 1'b0 && div_zero === 1'b0,
          "R10 results held", quotient, eq);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0, "R2 reset idle", {busy, done}, 0);
    chk(quotient === 0 && remainder === 0 && overflow === 0 && div_zero === 0,
        "R7 reset outputs", quotient, 0);
    rst_n = 1;
    run(0, 0, 16'h0000, 16'd100, 16'd7, 0, 1);
    run(0, 0, 16'hBEEF, 16'd100, 16'd7, 0, 0);
    run(1, 0, 16'h1234, 16'hFFF9, 16'd2, 0, 0);
    run(1, 0, 16'h0000, 16'd7, 16'hFFFE, 0, 0);
    run(1, 0, 16'h0000, 16'hFFF9, 16'hFFFE, 0, 0);
    run(1, 0, 16'h0000, 16'h8000, 16'hFFFF, 0, 0);
    run(1, 1, 16'h8000, 16'h0000, 16'hFFFF, 0, 0);
    run(0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF, 0, 1);
    run(0, 1, 16'hFFFF, 16'h0000, 16'hFFFF, 0, 0);
    run(1, 1, 16'hFFFE, 16'h8000, 16'd3, 0, 0);
    run(1, 1, 16'h0001, 16'h8000, 16'd3, 0, 0);
    run(0, 1, 16'h0000, 16'd5, 16'd0, 0, 0);
    run(1, 0, 16'h0000, 16'h8001, 16'd0, 0, 0);
    run(0, 1, 16'h0003, 16'h1234, 16'h0100, 1, 0);
    run(1, 0, 16'h0000, 16'hF000, 16'd9, 1, 0);
    for (int i = 0; i < 400; i++) begin
      bit s = $urandom_range(0, 1), w = $urandom_range(0, 1);
      logic [15:0] d = ($urandom_range(0, 15) == 0) ? 16'd0 : 16'($urandom);
      logic [15:0] hi = 16'($urandom);
      if (w && $urandom_range(0, 3) != 0) hi = 16'($urandom_range(0, 255)) ^ (s && hi[15] ? 16'hFFFF : 16'h0);
      run(s, w, hi, 16'($urandom), d, (i % 37) == 0, (i % 23) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule